// File: doc/BRIEF.md
# Memory Card Command Decoder and Response Generator

This block sits between a host-side register front end and the data path of an emulated memory card. Each accepted command strobe carries a 32-bit command word and a 32-bit argument. The block takes the opcode from the command word and builds the four 32-bit response words for that opcode. It then raises a completion pulse, together with an end-of-data pulse for opcodes that move data. Card-specific data (CSD) words come in on an input from a separate encoder and are passed through unchanged when they are requested.

For block read and write opcodes, the block turns the argument into a start sector. On a standard-capacity card the argument is a byte offset, and the block divides it by the programmed block length with an iterative divider. On a high-capacity card the argument is already a block address. The block hands the start sector, the block count and the direction to an external data mover, and it waits for the mover's done signal before it completes. Two opcodes return a short fixed data block, and the block streams it out one byte per cycle.

Top module: `mmc_cmd_engine`

## Requirements
- R1: The opcode is bits 5:0 of `cmd_word`. Bits 31:6 have no effect on any output.
- R2: When a command is accepted, `resp_words` is cleared to zero in the same edge and stays zero while `busy` is high. Each accepted command ends with exactly one single-cycle `end_cmd` pulse, and `busy` is low in that cycle. `resp_words` holds word 0 in bits 31:0 through word 3 in bits 127:96.
- R3: Response word 0 carries a card-state code in bits 12:9, the ready-for-data flag in bit 8 and the application flag in bit 5. Opcodes 13, 16, 17, 18, 24 and 25 return 0x900. Opcodes 6, 51 and 55 return 0x920. Opcode 7 returns 0x700. Opcode 12 returns 0xB00.
- R4: Opcode 9 returns `csd_words` as the four response words and latches `csd_hicap` into the high-capacity flag shown on `card_hicap`, which resets to 0. Opcode 8 echoes the argument in word 0. Opcode 41 returns 0x80FF8000 in word 0.
- R5: Opcode 16 loads the block length from the low LEN_W argument bits. The block length resets to 512 and is used by every later conversion.
- R6: A one-cycle `cnt_wr` sets the block count to `cnt_val`+1. Opcodes 17 and 24 set the stored count to 1 and transfer one block. Opcodes 18 and 25 transfer the stored count. `mv_write` is 1 for opcodes 24 and 25 and 0 for opcodes 17 and 18.
- R7: When the card is not high capacity, `mv_sector` is the argument divided by the block length, rounded down. A block length of zero gives all ones. When the card is high capacity, `mv_sector` is the argument unchanged.
- R8: A transfer on a card that is not high capacity, with argument bits 8:0 not all zero, sets `addr_misalign` at completion, and the transfer still runs. A high-capacity card never sets the flag. The flag holds its value until the next completion.
- R9: Each transfer gives one single-cycle `mv_start`. `mv_sector`, `mv_count` and `mv_write` stay stable until completion. `end_cmd` and `end_data` follow the first `mv_done` seen after the start cycle, and `mv_done` at any other time is ignored.
- R10: Opcode 6 with argument 0x00FFFFF1 or 0x80FFFFF1 streams 64 bytes on `dat_valid`/`dat_idx`/`dat_byte`, with index 0 to 63 in order, byte 13 equal to 2 and every other byte 0, and then sets `end_data`. With any other argument it streams nothing and does not set `end_data`.
- R11: Opcode 51 streams the 8 bytes 0x02, 0x25, 0, 0, 0, 0, 0, 0 and sets `end_data`.
- R12: Every opcode not named in R3 to R11 returns four zero words, with `end_cmd` set and `end_data` clear.
- R13: `cmd_valid` while `busy` is high is ignored. It produces no extra completion and no change to the responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_word | input | 32 | Command word; opcode in bits 5:0 |
| cmd_arg | input | 32 | Command argument |
| cnt_wr | input | 1 | Loads the block count |
| cnt_val | input | CNT_W | Block count minus one |
| csd_words | input | 128 | CSD words from the external encoder |
| csd_hicap | input | 1 | High-capacity indication from the encoder |
| busy | output | 1 | Command in progress |
| resp_words | output | 128 | Four response words |
| end_cmd | output | 1 | Completion pulse |
| end_data | output | 1 | End-of-data pulse, with end_cmd |
| addr_misalign | output | 1 | Byte offset not a multiple of 512 |
| card_hicap | output | 1 | Latched high-capacity flag |
| mv_start | output | 1 | Data mover start pulse |
| mv_write | output | 1 | Transfer direction, 1 = write |
| mv_sector | output | 32 | Start sector for the mover |
| mv_count | output | CNT_W | Blocks to move |
| mv_done | input | 1 | Mover finished |
| dat_valid | output | 1 | Stream byte valid |
| dat_idx | output | 6 | Stream byte index |
| dat_byte | output | 8 | Stream byte value |

## Verification
The bench sweeps all 64 opcodes with nonzero upper command bits. A decoder that looked at more than six bits, or that left stale words from the previous command, would return wrong response words. It also crosses several block lengths, including 3, 7 and zero, with arguments up to all ones. An off-by-one divider or a wrong divide-by-zero result would give a wrong sector.

Other cases cover the mode-dependent parts. One-block opcodes must overwrite the programmed count, and the bench checks that the forced count of one persists afterwards. A misaligned byte offset must raise the flag without stopping the transfer. A stray `mv_done` while idle, or a new strobe during a stream, must have no effect; a design that mishandled either would complete early or twice. The high-capacity switch must change addressing only after opcode 9 latches it.

// File: rtl/mmc_cmd_pkg.sv
// Shared opcodes, phase and kind types, and the status-word helpers
// for the command engine. Assumes 6-bit opcodes and 32-bit arguments.
package mmc_cmd_pkg;

    localparam logic [5:0] OP_SWITCH = 6'd6;
    localparam logic [5:0] OP_SELECT = 6'd7;
    localparam logic [5:0] OP_ECHO   = 6'd8;
    localparam logic [5:0] OP_CSD    = 6'd9;
    localparam logic [5:0] OP_STOP   = 6'd12;
    localparam logic [5:0] OP_STATUS = 6'd13;
    localparam logic [5:0] OP_BLKLEN = 6'd16;
    localparam logic [5:0] OP_RD1    = 6'd17;
    localparam logic [5:0] OP_RDN    = 6'd18;
    localparam logic [5:0] OP_WR1    = 6'd24;
    localparam logic [5:0] OP_WRN    = 6'd25;
    localparam logic [5:0] OP_OPCOND = 6'd41;
    localparam logic [5:0] OP_SCR    = 6'd51;
    localparam logic [5:0] OP_APP    = 6'd55;

    localparam logic [3:0] CS_STANDBY  = 4'd3;
    localparam logic [3:0] CS_TRANSFER = 4'd4;
    localparam logic [3:0] CS_SENDING  = 4'd5;

    localparam logic [31:0] OPCOND_WORD = 32'h80FF_8000;
    localparam logic [31:0] SW_ARG_LO   = 32'h00FF_FFF1;
    localparam logic [31:0] SW_ARG_HI   = 32'h80FF_FFF1;

    localparam int SW_LEN   = 64;
    localparam int SCR_LEN  = 8;
    localparam int IDX_W    = $clog2(SW_LEN);
    localparam int SW_MARK  = 13;

    typedef enum logic [2:0] {
        K_PLAIN, K_READ, K_WRITE, K_SWDATA, K_SCRDATA
    } kind_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_DIV, PH_MOVE, PH_STREAM, PH_FIN
    } phase_t;

    // Builds a status word: state code at 12:9, ready at 8, app flag at 5.
    function automatic logic [31:0] status_word(input logic [3:0] st, input logic app);
        status_word = (32'(st) << 9) | 32'h0000_0100 | (app ? 32'h0000_0020 : 32'h0);
    endfunction

    // Classifies an opcode and argument into its completion behaviour.
    function automatic kind_t kind_of(input logic [5:0] op, input logic [31:0] arg);
        case (op)
            OP_RD1, OP_RDN: kind_of = K_READ;
            OP_WR1, OP_WRN: kind_of = K_WRITE;
            OP_SWITCH:      kind_of = (arg == SW_ARG_LO || arg == SW_ARG_HI) ? K_SWDATA : K_PLAIN;
            OP_SCR:         kind_of = K_SCRDATA;
            default:        kind_of = K_PLAIN;
        endcase
    endfunction

endpackage

// File: rtl/mmc_resp_table.sv
// Response word table: maps a latched opcode and argument to the four
// response words. Purely combinational; assumes csd_in is held steady
// by its encoder while the command completes.
module mmc_resp_table
    import mmc_cmd_pkg::*;
(
    input  logic [5:0]   op,
    input  logic [31:0]  arg,
    input  logic [127:0] csd_in,
    output logic [127:0] resp
);

    // Selects the response words for the opcode; unknown opcodes give zero.
    always_comb begin
        resp = '0;
        case (op)
            OP_CSD:                        resp = csd_in;
            OP_ECHO:                       resp[31:0] = arg;
            OP_OPCOND:                     resp[31:0] = OPCOND_WORD;
            OP_SELECT:                     resp[31:0] = status_word(CS_STANDBY, 1'b0);
            OP_STOP:                       resp[31:0] = status_word(CS_SENDING, 1'b0);
            OP_SWITCH, OP_SCR, OP_APP:     resp[31:0] = status_word(CS_TRANSFER, 1'b1);
            OP_STATUS, OP_BLKLEN,
            OP_RD1, OP_RDN, OP_WR1, OP_WRN: resp[31:0] = status_word(CS_TRANSFER, 1'b0);
            default:                       resp = '0;
        endcase
    end

endmodule

// File: rtl/mmc_sector_div.sv
// Restoring divider, one quotient bit per cycle. Converts a byte offset
// into a sector number. Takes W cycles after start; done pulses one
// cycle with the quotient valid. A zero divisor yields all ones.
module mmc_sector_div #(
    parameter int W  = 32,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  dividend,
    input  logic [DW-1:0] divisor,
    output logic [W-1:0]  quotient,
    output logic          done
);

    localparam int CW = $clog2(W + 1);

    logic [W:0]    rem_q;
    logic [W-1:0]  quo_q;
    logic [DW-1:0] dsr_q;
    logic [CW-1:0] left_q;
    logic          run_q;
    logic          done_q;
    logic [W:0]    shifted;
    logic [W:0]    dsr_ext;

    assign shifted  = {rem_q[W-1:0], quo_q[W-1]};
    assign dsr_ext  = (W + 1)'(dsr_q);
    assign quotient = quo_q;
    assign done     = done_q;

    // Loads operands on start, then shifts and subtracts once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dsr_q  <= '0;
            left_q <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                rem_q  <= '0;
                quo_q  <= dividend;
                dsr_q  <= divisor;
                left_q <= CW'(W);
                run_q  <= 1'b1;
            end else if (run_q) begin
                if (shifted >= dsr_ext) begin
                    rem_q <= shifted - dsr_ext;
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted;
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                left_q <= left_q - 1'b1;
                if (left_q == CW'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mmc_blob_gen.sv
// Fixed data block generator for the switch-status and configuration
// replies. Gives the byte at an index and flags the final index.
// Combinational; assumes kind is one of the two streaming kinds when used.
module mmc_blob_gen
    import mmc_cmd_pkg::*;
(
    input  kind_t            kind,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       data,
    output logic             last
);

    // Picks the byte value and end marker for the active block.
    always_comb begin
        data = 8'h00;
        last = 1'b0;
        if (kind == K_SWDATA) begin
            data = (idx == IDX_W'(SW_MARK)) ? 8'h02 : 8'h00;
            last = (idx == IDX_W'(SW_LEN - 1));
        end else if (kind == K_SCRDATA) begin
            case (idx)
                IDX_W'(0): data = 8'h02;
                IDX_W'(1): data = 8'h25;
                default:   data = 8'h00;
            endcase
            last = (idx == IDX_W'(SCR_LEN - 1));
        end
    end

endmodule

// File: rtl/mmc_cmd_engine.sv
// Command decoder and response generator. Accepts one command at a time,
// converts transfer addresses, hands transfers to an external mover and
// streams the short fixed data blocks. Assumes the mover answers each
// mv_start with one mv_done pulse and csd inputs are steady per command.
module mmc_cmd_engine
    import mmc_cmd_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int CNT_W      = 16,
    parameter int DEF_BLKLEN = 512
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [31:0]        cmd_word,
    input  logic [31:0]        cmd_arg,
    input  logic               cnt_wr,
    input  logic [CNT_W-1:0]   cnt_val,
    input  logic [127:0]       csd_words,
    input  logic               csd_hicap,
    output logic               busy,
    output logic [127:0]       resp_words,
    output logic               end_cmd,
    output logic               end_data,
    output logic               addr_misalign,
    output logic               card_hicap,
    output logic               mv_start,
    output logic               mv_write,
    output logic [31:0]        mv_sector,
    output logic [CNT_W-1:0]   mv_count,
    input  logic               mv_done,
    output logic               dat_valid,
    output logic [5:0]         dat_idx,
    output logic [7:0]         dat_byte
);

    localparam int ALIGN_BITS = 9;

    phase_t             phase_q;
    logic [5:0]         op_q;
    logic [31:0]        arg_q;
    kind_t              kind_q;
    logic [LEN_W-1:0]   blklen_q;
    logic [CNT_W-1:0]   blkcnt_q;
    logic               hicap_q;
    logic               mis_q;
    logic               mis_out_q;
    logic [IDX_W-1:0]   idx_q;
    logic [127:0]       resp_q;
    logic               end_cmd_q;
    logic               end_data_q;
    logic               mv_start_q;
    logic               mv_write_q;
    logic [31:0]        mv_sector_q;
    logic [CNT_W-1:0]   mv_count_q;

    logic [5:0]         new_op;
    kind_t              new_kind;
    logic               new_xfer;
    logic               accept;
    logic               div_start;
    logic [31:0]        div_quo;
    logic               div_done;
    logic [127:0]       tbl_resp;
    logic [7:0]         blob_byte;
    logic               blob_last;

    assign new_op    = cmd_word[5:0];
    assign new_kind  = kind_of(new_op, cmd_arg);
    assign new_xfer  = (new_kind == K_READ) || (new_kind == K_WRITE);
    assign accept    = cmd_valid && (phase_q == PH_IDLE);
    assign div_start = accept && new_xfer && !hicap_q;

    mmc_resp_table u_table (
        .op     (op_q),
        .arg    (arg_q),
        .csd_in (csd_words),
        .resp   (tbl_resp)
    );

    mmc_sector_div #(.W(32), .DW(LEN_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (cmd_arg),
        .divisor  (blklen_q),
        .quotient (div_quo),
        .done     (div_done)
    );

    mmc_blob_gen u_blob (
        .kind (kind_q),
        .idx  (idx_q),
        .data (blob_byte),
        .last (blob_last)
    );

    // Sequences one command from acceptance to its completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            op_q        <= '0;
            arg_q       <= '0;
            kind_q      <= K_PLAIN;
            blklen_q    <= LEN_W'(DEF_BLKLEN);
            blkcnt_q    <= CNT_W'(1);
            hicap_q     <= 1'b0;
            mis_q       <= 1'b0;
            mis_out_q   <= 1'b0;
            idx_q       <= '0;
            resp_q      <= '0;
            end_cmd_q   <= 1'b0;
            end_data_q  <= 1'b0;
            mv_start_q  <= 1'b0;
            mv_write_q  <= 1'b0;
            mv_sector_q <= '0;
            mv_count_q  <= '0;
        end else begin
            end_cmd_q  <= 1'b0;
            end_data_q <= 1'b0;
            mv_start_q <= 1'b0;
            if (cnt_wr) begin
                blkcnt_q <= cnt_val + CNT_W'(1);
            end
            case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        op_q   <= new_op;
                        arg_q  <= cmd_arg;
                        kind_q <= new_kind;
                        resp_q <= '0;
                        mis_q  <= new_xfer && !hicap_q && (cmd_arg[ALIGN_BITS-1:0] != '0);
                        if (new_xfer) begin
                            mv_write_q <= (new_kind == K_WRITE);
                            if (new_op == OP_RD1 || new_op == OP_WR1) begin
                                blkcnt_q   <= CNT_W'(1);
                                mv_count_q <= CNT_W'(1);
                            end else begin
                                mv_count_q <= blkcnt_q;
                            end
                            if (hicap_q) begin
                                mv_sector_q <= cmd_arg;
                                mv_start_q  <= 1'b1;
                                phase_q     <= PH_MOVE;
                            end else begin
                                phase_q <= PH_DIV;
                            end
                        end else if (new_kind == K_SWDATA || new_kind == K_SCRDATA) begin
                            idx_q   <= '0;
                            phase_q <= PH_STREAM;
                        end else begin
                            phase_q <= PH_FIN;
                        end
                    end
                end
                PH_DIV: begin
                    if (div_done) begin
                        mv_sector_q <= div_quo;
                        mv_start_q  <= 1'b1;
                        phase_q     <= PH_MOVE;
                    end
                end
                PH_MOVE: begin
                    if (mv_done && !mv_start_q) begin
                        phase_q <= PH_FIN;
                    end
                end
                PH_STREAM: begin
                    if (blob_last) begin
                        phase_q <= PH_FIN;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                PH_FIN: begin
                    resp_q     <= tbl_resp;
                    end_cmd_q  <= 1'b1;
                    end_data_q <= (kind_q != K_PLAIN);
                    mis_out_q  <= mis_q;
                    if (op_q == OP_CSD) begin
                        hicap_q <= csd_hicap;
                    end
                    if (op_q == OP_BLKLEN) begin
                        blklen_q <= arg_q[LEN_W-1:0];
                    end
                    phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy          = (phase_q != PH_IDLE);
    assign resp_words    = resp_q;
    assign end_cmd       = end_cmd_q;
    assign end_data      = end_data_q;
    assign addr_misalign = mis_out_q;
    assign card_hicap    = hicap_q;
    assign mv_start      = mv_start_q;
    assign mv_write      = mv_write_q;
    assign mv_sector     = mv_sector_q;
    assign mv_count      = mv_count_q;
    assign dat_valid     = (phase_q == PH_STREAM);
    assign dat_idx       = 6'(idx_q);
    assign dat_byte      = blob_byte;

endmodule

// File: rtl/mmc_cmd_engine_chk.sv
// Protocol checker for the command engine, attached by bind. Observes
// ports only; assumes the synchronous active-low reset of the design.
module mmc_cmd_engine_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         busy,
    input logic [127:0] resp_words,
    input logic         end_cmd,
    input logic         end_data,
    input logic         addr_misalign,
    input logic         card_hicap,
    input logic         mv_start,
    input logic         dat_valid,
    input logic [5:0]   dat_idx
);

    // R2: responses are cleared when a command starts.
    p_clear_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (resp_words == '0));

    // R2: completion is reported with the engine idle.
    p_end_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        end_cmd |-> !busy);

    // R2: responses change only at start or completion.
    p_resp_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!end_cmd && !$rose(busy)) |-> $stable(resp_words));

    // R10: end of data never appears without end of command.
    p_data_with_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        end_data |-> end_cmd);

    // R10: stream indices advance by one on consecutive bytes.
    p_idx_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_valid && $past(dat_valid)) |-> (dat_idx == $past(dat_idx) + 6'd1));

    // R9: the mover start is a single-cycle pulse.
    p_start_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mv_start |=> !mv_start);

    // R9: a mover start happens only inside a command.
    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mv_start |-> busy);

    // R8: misalignment is never reported on a high-capacity card.
    p_hicap_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (end_cmd && addr_misalign) |-> !card_hicap);

endmodule

bind mmc_cmd_engine mmc_cmd_engine_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .resp_words    (resp_words),
    .end_cmd       (end_cmd),
    .end_data      (end_data),
    .addr_misalign (addr_misalign),
    .card_hicap    (card_hicap),
    .mv_start      (mv_start),
    .dat_valid     (dat_valid),
    .dat_idx       (dat_idx)
);

// File: tb/sim_mmc_cmd_engine.sv
module sim_mmc_cmd_engine;

    localparam int PERIOD = 10;
    localparam int CNT_W  = 16;
    localparam logic [127:0] CSD_PAT = 128'hC5D0_1234_0BAD_F00D_7E57_AB12_3456_89EF;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cmd_valid = 1'b0;
    logic [31:0]        cmd_word = '0;
    logic [31:0]        cmd_arg = '0;
    logic               cnt_wr = 1'b0;
    logic [CNT_W-1:0]   cnt_val = '0;
    logic               csd_hicap = 1'b0;
    logic               mv_done = 1'b0;
    logic               busy, end_cmd, end_data, addr_misalign, card_hicap;
    logic               mv_start, mv_write, dat_valid;
    logic [127:0]       resp_words;
    logic [31:0]        mv_sector;
    logic [CNT_W-1:0]   mv_count;
    logic [5:0]         dat_idx;
    logic [7:0]         dat_byte;

    int checks = 0;
    int fails  = 0;

    // bench model of the block state
    bit          m_hicap = 0;
    logic [15:0] m_len   = 16'd512;
    logic [15:0] m_cnt   = 16'd1;

    // observations of the last command
    bit           o_busy0;
    logic [127:0] o_resp0, o_resp;
    bit           o_edata, o_mis, o_wr, o_done_given;
    int           o_starts, o_bytes, o_byte_err;
    logic [31:0]  o_sector;
    logic [15:0]  o_count;

    always #(PERIOD/2) clk = ~clk;

    mmc_cmd_engine u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .cmd_arg(cmd_arg), .cnt_wr(cnt_wr), .cnt_val(cnt_val), .csd_words(CSD_PAT),
        .csd_hicap(csd_hicap), .busy(busy), .resp_words(resp_words), .end_cmd(end_cmd),
        .end_data(end_data), .addr_misalign(addr_misalign), .card_hicap(card_hicap),
        .mv_start(mv_start), .mv_write(mv_write), .mv_sector(mv_sector),
        .mv_count(mv_count), .mv_done(mv_done), .dat_valid(dat_valid),
        .dat_idx(dat_idx), .dat_byte(dat_byte)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] st_word(input int st, input int app);
        return 32'(st * 512 + 256 + app * 32);
    endfunction

    function automatic logic [127:0] exp_resp(input logic [5:0] op, input logic [31:0] a);
        case (op)
            6'd6, 6'd51, 6'd55: return {96'h0, st_word(4, 1)};
            6'd13, 6'd16, 6'd17, 6'd18, 6'd24, 6'd25: return {96'h0, st_word(4, 0)};
            6'd7:  return {96'h0, st_word(3, 0)};
            6'd12: return {96'h0, st_word(5, 0)};
            6'd8:  return {96'h0, a};
            6'd41: return {96'h0, 32'h80FF8000};
            6'd9:  return CSD_PAT;
            default: return '0;
        endcase
    endfunction

    // Issues one command, plays the mover, collects the outcome.
    task automatic issue(input logic [31:0] w, input logic [31:0] a, input bit poke);
        int  cyc = 0;
        int  cd  = 0;
        bit  sw  = (w[5:0] == 6'd6) && (a == 32'h00FFFFF1 || a == 32'h80FFFFF1);
        bit  scr = (w[5:0] == 6'd51);
        logic [7:0] eb;
        @(negedge clk);
        while (busy) @(negedge clk);
        cmd_word = w; cmd_arg = a; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        o_busy0 = busy; o_resp0 = resp_words;
        o_starts = 0; o_bytes = 0; o_byte_err = 0; o_done_given = 0;
        o_sector = '0; o_count = '0; o_wr = 0;
        while (!end_cmd && cyc < 3000) begin
            if (mv_start) begin
                o_starts++; o_sector = mv_sector; o_count = mv_count; o_wr = mv_write; cd = 3;
            end
            if (dat_valid) begin
                eb = 8'h00;
                if (sw && dat_idx == 6'd13) eb = 8'h02;
                if (scr && dat_idx == 6'd0) eb = 8'h02;
                if (scr && dat_idx == 6'd1) eb = 8'h25;
                if (dat_byte != eb || int'(dat_idx) != o_bytes) o_byte_err++;
                o_bytes++;
            end
            if (poke && cyc == 4) begin
                cmd_valid = 1'b1; cmd_word = 32'd8; cmd_arg = 32'hDEAD_0000;
            end else begin
                cmd_valid = 1'b0;
            end
            mv_done = (cd == 1);
            if (mv_done) o_done_given = 1;
            if (cd > 0) cd--;
            @(negedge clk);
            cyc++;
        end
        mv_done = 1'b0; cmd_valid = 1'b0;
        o_resp = resp_words; o_edata = end_data; o_mis = addr_misalign;
    endtask

    // Runs a command and checks it against the bench model.
    task automatic run_check(input logic [31:0] w, input logic [31:0] a);
        logic [5:0] op = w[5:0];
        bit xfer = (op == 6'd17 || op == 6'd18 || op == 6'd24 || op == 6'd25);
        bit sw   = (op == 6'd6) && (a == 32'h00FFFFF1 || a == 32'h80FFFFF1);
        bit scr  = (op == 6'd51);
        logic [31:0] esec;
        logic [15:0] ecnt;
        issue(w, a, 1'b0);
        chk(o_busy0 && o_resp0 == '0, "R2 clear at start", o_resp0, 0);
        chk(o_resp == exp_resp(op, a), $sformatf("R1/R3/R4/R12 resp op=%0d", op), o_resp, exp_resp(op, a));
        chk(o_edata == (xfer || sw || scr), $sformatf("R10/R11/R12 end_data op=%0d", op), o_edata, xfer || sw || scr);
        if (xfer) begin
            esec = m_hicap ? a : (m_len == 0 ? 32'hFFFF_FFFF : a / 32'(m_len));
            ecnt = (op == 6'd17 || op == 6'd24) ? 16'd1 : m_cnt;
            chk(o_starts == 1 && o_done_given, "R9 one start, done before end", o_starts, 1);
            chk(o_sector == esec, $sformatf("R7 sector arg=%0h len=%0d", a, m_len), o_sector, esec);
            chk(o_count == ecnt, "R6 count", o_count, ecnt);
            chk(o_wr == (op == 6'd24 || op == 6'd25), "R6 direction", o_wr, op == 6'd24 || op == 6'd25);
            chk(o_mis == (!m_hicap && a[8:0] != 0), "R8 misalign", o_mis, !m_hicap && a[8:0] != 0);
            if (op == 6'd17 || op == 6'd24) m_cnt = 16'd1;
        end else begin
            chk(o_starts == 0, "R9 no mover start", o_starts, 0);
            chk(o_mis == 0, "R8 misalign clear", o_mis, 0);
        end
        if (sw || scr) begin
            chk(o_bytes == (sw ? 64 : 8) && o_byte_err == 0,
                sw ? "R10 switch block" : "R11 config block", o_byte_err, 0);
        end else begin
            chk(o_bytes == 0, "R10 no stream", o_bytes, 0);
        end
        if (op == 6'd9) m_hicap = csd_hicap;
        if (op == 6'd16) m_len = a[15:0];
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] lens [5] = '{16'd512, 16'd1024, 16'd3, 16'd7, 16'd0};
        logic [31:0] args [4] = '{32'h0, 32'h1234, 32'hFFFF_FFFF, 32'h8000_0001};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && resp_words == '0 && !end_cmd && !mv_start && !dat_valid && !card_hicap,
            "R2 R4 reset state", resp_words, 0);

        // R1 R3 R4 R12: every opcode with nonzero upper command bits
        for (int op = 0; op < 64; op++) begin
            logic [31:0] a;
            if (op == 6) a = 32'h80FF_FFF1;
            else if (op == 17 || op == 18 || op == 24 || op == 25) a = 32'h0001_0400;
            else if (op == 16) a = 32'd512;
            else a = 32'h1357_9BDF;
            run_check({26'h3A5C0F1, 6'(op)}, a);
        end

        // R6: programmed count, then the forced count of one persists
        cnt_val = 16'd5; cnt_wr = 1'b1; @(negedge clk); cnt_wr = 1'b0; m_cnt = 16'd6;
        run_check(32'd18, 32'h2200);
        run_check(32'd24, 32'h400);
        run_check(32'd25, 32'h600);

        // R9: a stray mover done while idle is ignored
        mv_done = 1'b1; @(negedge clk); mv_done = 1'b0;
        chk(!end_cmd && !busy, "R9 idle done ignored", end_cmd, 0);
        run_check(32'd17, 32'h1000);

        // R10: other switch arguments stream nothing
        run_check(32'd6, 32'h00FF_FFF0);
        run_check(32'd6, 32'h00FF_FFF1);
        run_check(32'd51, 32'h0);

        // R13: strobe during a stream is ignored
        issue(32'd6, 32'h00FF_FFF1, 1'b1);
        chk(o_resp == exp_resp(6'd6, 0) && o_bytes == 64, "R13 busy strobe ignored", o_resp, exp_resp(6'd6, 0));
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(!end_cmd && !busy, "R13 no extra completion", end_cmd, 0);
        end
        chk(resp_words == exp_resp(6'd6, 0), "R13 response kept", resp_words, exp_resp(6'd6, 0));

        // R5 R7 R8: block lengths crossed with arguments
        for (int li = 0; li < 5; li++) begin
            run_check(32'd16, 32'(lens[li]));
            for (int ai = 0; ai < 4; ai++) begin
                run_check((ai % 2 == 0) ? 32'd18 : 32'd25, args[ai]);
            end
        end
        run_check(32'd16, 32'd512);

        // R4 R7 R8: high-capacity addressing after the CSD latches the flag
        csd_hicap = 1'b1;
        run_check(32'd13, 32'h0);
        run_check(32'd18, 32'h1235);
        run_check(32'd9, 32'h0);
        chk(card_hicap == 1'b1, "R4 high capacity latched", card_hicap, 1);
        run_check(32'd25, 32'h1235);
        run_check(32'd17, 32'hFFFF_FFFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule